// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block resolves a translation miss by searching an in-memory hashed page table. A request carries the segment's virtual ID, the 16-bit page index taken from address bits 27..12, the two protection-key bits of the segment, the privilege mode and the access direction. The block hashes these into the address of a 64-byte group of eight two-word entries. It reads the group through a one-cycle-latency memory port and looks for a valid entry whose tag matches. If the first group yields no match, the block searches a second group at the complemented hash.

When a match is found, the block checks that every other match in the same group agrees on the translation fields. It then decodes the page-protection bits against the access key and grants or refuses the access. On a granted access it sets the referenced bit, and also the changed bit for a store, and writes the updated second word back to memory. The result is a one-cycle done pulse with a two-bit outcome code, the real page number and the granted read and write permissions.

Top module: `hpt_walker`

## Requirements
- R1: The first group address is `{tbl_origin, 16'h0} | (H & M)`. Here `H = ((vsid[18:0] ^ pidx) << 6)` as a 32-bit value and `M = {7'b0, tbl_size, 16'hFFC0}`.
- R2: The second group uses `H2 = ~H & 32'h01FFFFC0` in place of `H`. It is read only when the first group holds no matching entry; any match in the first group ends the walk after that group.
- R3: An entry matches only if its first word has bit 31 set, its bit 6 equals the pass (0 first group, 1 second group), and `(w0 & 32'h7FFFFFBF) == {1'b0, vsid, 1'b0, pidx[15:10]}`.
- R4: When two or more entries in a group match, their second words must agree under mask `32'hFFFFF07B`. Any disagreement ends the walk with outcome 3 and no memory write. Agreeing duplicates resolve to the lowest-numbered matching slot.
- R5: The access key is 1 when `req_user` is 1 and `seg_key_usr` is 1, or when `req_user` is 0 and `seg_key_sup` is 1. Otherwise the key is 0.
- R6: The page-protection field is bits 1..0 of the second word. With key 0, reads are allowed and writes are allowed unless the field is 3. With key 1, field 0 allows nothing, fields 1 and 3 allow reads only, and field 2 allows both. A refused access gives outcome 2.
- R7: On a granted access, bit 8 is set in the second word, and bit 7 is also set for a write. The word is written to the matching slot's second-word address only if it changed. A refused access never writes.
- R8: `perm_write` is 1 only when writes are allowed and either the access is a write or bit 7 of the stored word was already 1.
- R9: On a hit, `real_page` equals bits 31..12 of the matching second word.
- R10: `status` encodes 0 hit, 1 no match in either group, 2 protection refusal, 3 inconsistent matches. `perm_read` and `perm_write` are 0 unless the outcome is a hit. `done` is high for exactly one cycle per request.
- R11: Slot i is read at group address + 8*i (first word) and + 8*i + 4 (second word). The data is taken the cycle after `mem_rd_en`. Every slot of each searched group is read, so a walk makes 16 reads for one group and 32 for two. A read and a write never share a cycle.
- R12: After reset the block is idle, with `busy`, `done`, `mem_rd_en` and `mem_wr_en` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (sampled only while idle) |
| req_vsid | input | 24 | Segment virtual ID |
| req_pidx | input | 16 | Page index, address bits 27..12 |
| req_write | input | 1 | 1 for a store access |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| seg_key_sup | input | 1 | Segment key bit applied in supervisor mode |
| seg_key_usr | input | 1 | Segment key bit applied in user mode |
| tbl_origin | input | 16 | Table base, address bits 31..16 |
| tbl_size | input | 9 | Table size mask for hash bits 24..16 |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Updated second word to store |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Walk outcome code |
| real_page | output | 20 | Real page number on a hit |
| perm_read | output | 1 | Read granted |
| perm_write | output | 1 | Write granted without a later status-bit fault |

## Verification
The checks assume that `req_valid` is raised only while `busy` is low. They also assume that memory answers every read with data on the following cycle and that nothing else changes the table during a walk. The bench keeps to these conditions. It issues each request at a falling edge only after the previous `done` pulse. Its memory model returns read data registered on the clock edge that samples the strobe, and it changes table contents only between walks.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
    localparam int VSID_W   = 24;
    localparam int PIDX_W   = 16;
    localparam int API_W    = 6;
    localparam int HASH_W   = 19;
    localparam int RPN_W    = 20;
    localparam int ORG_W    = 16;
    localparam int SIZE_W   = 9;
    localparam int WORD_W   = 32;

    localparam logic [WORD_W-1:0] CONS_MASK = 32'hFFFFF07B;
    localparam logic [WORD_W-1:0] TAG_MASK  = 32'h7FFFFFBF;
    localparam logic [WORD_W-1:0] SEC_MASK  = 32'h01FFFFC0;
    localparam logic [WORD_W-1:0] REF_FLAG  = 32'h00000100;
    localparam logic [WORD_W-1:0] CHG_FLAG  = 32'h00000080;

    typedef enum logic [1:0] {
        WALK_HIT      = 2'd0,
        WALK_NOTFOUND = 2'd1,
        WALK_PROT     = 2'd2,
        WALK_CONFLICT = 2'd3
    } walk_status_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD0    = 3'd1,
        ST_RD1    = 3'd2,
        ST_CHK    = 3'd3,
        ST_DECIDE = 3'd4,
        ST_WB     = 3'd5
    } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [HASH_W-1:0] hvsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [ORG_W-1:0]  tbl_origin,
    input  logic [SIZE_W-1:0] tbl_size,
    input  logic              secondary,
    output logic [WORD_W-1:0] group_addr
);
    localparam int TOP_PAD = WORD_W - HASH_W - 6;
    localparam int SZ_PAD  = WORD_W - SIZE_W - 16;

    logic [WORD_W-1:0] hash_pri;
    logic [WORD_W-1:0] hash_sel;
    logic [WORD_W-1:0] size_mask;

    always_comb begin
        hash_pri  = {{TOP_PAD{1'b0}}, (hvsid ^ {{(HASH_W-PIDX_W){1'b0}}, pidx}), 6'b0};
        hash_sel  = secondary ? (~hash_pri & SEC_MASK) : hash_pri;
        size_mask = {{SZ_PAD{1'b0}}, tbl_size, 16'hFFC0};
        group_addr = {tbl_origin, 16'h0} | (hash_sel & size_mask);
    end
endmodule

// File: rtl/hpt_entry_match.sv
`timescale 1ns/1ps
module hpt_entry_match
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              pass_sec,
    output logic              hit
);
    logic [WORD_W-1:0] tag;

    always_comb begin
        tag = {1'b0, vsid, 1'b0, api};
        hit = word0[31] && (word0[6] == pass_sec) && ((word0 & TAG_MASK) == tag);
    end
endmodule

// File: rtl/hpt_rights.sv
`timescale 1ns/1ps
module hpt_rights (
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       is_write,
    output logic       can_rd,
    output logic       can_wr,
    output logic       granted
);
    always_comb begin
        if (!key) begin
            can_rd = 1'b1;
            can_wr = (pp != 2'd3);
        end else begin
            unique case (pp)
                2'd0:    begin can_rd = 1'b0; can_wr = 1'b0; end
                2'd2:    begin can_rd = 1'b1; can_wr = 1'b1; end
                default: begin can_rd = 1'b1; can_wr = 1'b0; end
            endcase
        end
        granted = is_write ? can_wr : can_rd;
    end
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_SLOTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [PIDX_W-1:0] req_pidx,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              seg_key_sup,
    input  logic              seg_key_usr,
    input  logic [ORG_W-1:0]  tbl_origin,
    input  logic [SIZE_W-1:0] tbl_size,
    output logic              busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        status,
    output logic [RPN_W-1:0]  real_page,
    output logic              perm_read,
    output logic              perm_write
);
    localparam int IDX_W   = (GROUP_SLOTS > 1) ? $clog2(GROUP_SLOTS) : 1;
    localparam int OFF_PAD = WORD_W - IDX_W - 3;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_SLOTS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic              pass_sec;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  first_idx;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] keep;
        logic [WORD_W-1:0] wb_word;
        logic              found;
        logic              conflict;
        logic [VSID_W-1:0] vsid;
        logic [PIDX_W-1:0] pidx;
        logic              wr;
        logic              key;
        logic [ORG_W-1:0]  origin;
        logic [SIZE_W-1:0] size;
        logic              done;
        walk_status_e      status;
        logic [RPN_W-1:0]  rpn;
        logic              pr;
        logic              pw;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [WORD_W-1:0] group_addr;
    logic              slot_hit;
    logic              can_rd, can_wr, granted;
    logic [WORD_W-1:0] updated;
    logic [IDX_W-1:0]  port_slot;
    logic              upper_word;

    hpt_hash u_hash (
        .hvsid      (q.vsid[HASH_W-1:0]),
        .pidx       (q.pidx),
        .tbl_origin (q.origin),
        .tbl_size   (q.size),
        .secondary  (q.pass_sec),
        .group_addr (group_addr)
    );

    hpt_entry_match u_match (
        .word0    (q.w0),
        .vsid     (q.vsid),
        .api      (q.pidx[PIDX_W-1 -: API_W]),
        .pass_sec (q.pass_sec),
        .hit      (slot_hit)
    );

    hpt_rights u_rights (
        .key      (q.key),
        .pp       (q.keep[1:0]),
        .is_write (q.wr),
        .can_rd   (can_rd),
        .can_wr   (can_wr),
        .granted  (granted)
    );

    assign updated = q.keep | REF_FLAG | (q.wr ? CHG_FLAG : '0);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vsid     = req_vsid;
                    d.pidx     = req_pidx;
                    d.wr       = req_write;
                    d.key      = (req_user & seg_key_usr) | (~req_user & seg_key_sup);
                    d.origin   = tbl_origin;
                    d.size     = tbl_size;
                    d.pass_sec = 1'b0;
                    d.idx      = '0;
                    d.found    = 1'b0;
                    d.conflict = 1'b0;
                    d.st       = ST_RD0;
                end
            end
            ST_RD0: d.st = ST_RD1;
            ST_RD1: begin
                d.w0 = mem_rdata;
                d.st = ST_CHK;
            end
            ST_CHK: begin
                if (slot_hit) begin
                    if (!q.found) begin
                        d.found     = 1'b1;
                        d.first_idx = q.idx;
                        d.keep      = mem_rdata;
                    end else if (((q.keep ^ mem_rdata) & CONS_MASK) != '0) begin
                        d.conflict = 1'b1;
                    end
                end
                if (q.idx == LAST_SLOT) begin
                    d.st = ST_DECIDE;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_RD0;
                end
            end
            ST_DECIDE: begin
                d.pr  = 1'b0;
                d.pw  = 1'b0;
                d.rpn = '0;
                if (q.conflict) begin
                    d.status = WALK_CONFLICT;
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end else if (q.found) begin
                    if (granted) begin
                        d.status  = WALK_HIT;
                        d.rpn     = q.keep[WORD_W-1 -: RPN_W];
                        d.pr      = can_rd;
                        d.pw      = can_wr & (q.keep[7] | q.wr);
                        d.wb_word = updated;
                        if (updated != q.keep) begin
                            d.st = ST_WB;
                        end else begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end else begin
                        d.status = WALK_PROT;
                        d.done   = 1'b1;
                        d.st     = ST_IDLE;
                    end
                end else if (!q.pass_sec) begin
                    d.pass_sec = 1'b1;
                    d.idx      = '0;
                    d.st       = ST_RD0;
                end else begin
                    d.status = WALK_NOTFOUND;
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            ST_WB: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign port_slot  = (q.st == ST_WB) ? q.first_idx : q.idx;
    assign upper_word = (q.st == ST_RD1) || (q.st == ST_WB);

    assign mem_addr   = group_addr + {{OFF_PAD{1'b0}}, port_slot, 3'b000}
                      + (upper_word ? WORD_W'(4) : WORD_W'(0));
    assign mem_rd_en  = (q.st == ST_RD0) || (q.st == ST_RD1);
    assign mem_wr_en  = (q.st == ST_WB);
    assign mem_wdata  = q.wb_word;
    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign status     = q.status;
    assign real_page  = q.rpn;
    assign perm_read  = q.pr;
    assign perm_write = q.pw;
endmodule

// File: rtl/hpt_walker_chk.sv
`timescale 1ns/1ps
module hpt_walker_chk
    import hpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       perm_read,
    input logic       perm_write,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [2:0] addr_lo,
    input logic       ref_bit
);
    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_read_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (addr_lo[1:0] == 2'b00));

    assert_wb_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (addr_lo == 3'b100) && ref_bit);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_perm_only_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != WALK_HIT) |-> (!perm_read && !perm_write));

    assert_hit_readable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == WALK_HIT) |-> perm_read);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .perm_read  (perm_read),
    .perm_write (perm_write),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .addr_lo    (mem_addr[2:0]),
    .ref_bit    (mem_wdata[8])
);

// File: tb/hpt_walker_test.sv
`timescale 1ns/1ps
module hpt_walker_test;
    localparam logic [1:0] S_HIT = 2'd0, S_NONE = 2'd1, S_PROT = 2'd2, S_CONF = 2'd3;
    localparam logic [15:0] ORG = 16'h0040;
    localparam logic [8:0]  SZ  = 9'h000;

    typedef struct packed {
        logic [23:0] vsid;
        logic [15:0] pidx;
        logic        wr, usr, ks, kp;
        logic [1:0]  pp;
        logic [1:0]  where;   // 0 absent, 1 first group, 2 second group
        logic [2:0]  slot;
        logic [1:0]  rc;      // {referenced, changed}
        logic [1:0]  est;
        logic        er, ew;
        logic [31:0] eword;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{24'h000A51, 16'h1234, 1'b0,1'b0,1'b0,1'b0, 2'd2, 2'd1, 3'd3, 2'b00, S_HIT,  1'b1,1'b0, 32'h12345102},
        '{24'h0F0F0F, 16'hFC01, 1'b1,1'b0,1'b0,1'b0, 2'd2, 2'd2, 3'd7, 2'b00, S_HIT,  1'b1,1'b1, 32'h12345182},
        '{24'h123456, 16'h0040, 1'b1,1'b0,1'b0,1'b0, 2'd3, 2'd1, 3'd0, 2'b00, S_PROT, 1'b0,1'b0, 32'h12345003},
        '{24'hABCDEF, 16'h8000, 1'b0,1'b1,1'b0,1'b1, 2'd0, 2'd1, 3'd5, 2'b00, S_PROT, 1'b0,1'b0, 32'h12345000},
        '{24'h000001, 16'h0001, 1'b0,1'b1,1'b0,1'b1, 2'd1, 2'd1, 3'd2, 2'b11, S_HIT,  1'b1,1'b0, 32'h12345181},
        '{24'h7FFF00, 16'h5A5A, 1'b1,1'b1,1'b0,1'b1, 2'd2, 2'd2, 3'd4, 2'b10, S_HIT,  1'b1,1'b1, 32'h12345182},
        '{24'h222222, 16'h3333, 1'b0,1'b0,1'b0,1'b0, 2'd2, 2'd0, 3'd0, 2'b00, S_NONE, 1'b0,1'b0, 32'h00000000},
        '{24'h0055AA, 16'hFFFF, 1'b0,1'b0,1'b1,1'b0, 2'd3, 2'd1, 3'd6, 2'b00, S_HIT,  1'b1,1'b0, 32'h12345103},
        '{24'h300000, 16'h0C00, 1'b0,1'b0,1'b0,1'b0, 2'd0, 2'd1, 3'd1, 2'b01, S_HIT,  1'b1,1'b1, 32'h12345180},
        '{24'h010203, 16'h0707, 1'b1,1'b1,1'b1,1'b0, 2'd1, 2'd1, 3'd0, 2'b00, S_HIT,  1'b1,1'b1, 32'h12345181}
    };

    logic        clk, rst_n;
    logic        req_valid, req_write, req_user, seg_key_sup, seg_key_usr;
    logic [23:0] req_vsid;
    logic [15:0] req_pidx, tbl_origin;
    logic [8:0]  tbl_size;
    logic        busy, mem_rd_en, mem_wr_en, done, perm_read, perm_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  status;
    logic [19:0] real_page;

    hpt_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vsid(req_vsid),
        .req_pidx(req_pidx), .req_write(req_write), .req_user(req_user),
        .seg_key_sup(seg_key_sup), .seg_key_usr(seg_key_usr),
        .tbl_origin(tbl_origin), .tbl_size(tbl_size), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .status(status), .real_page(real_page), .perm_read(perm_read),
        .perm_write(perm_write)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] mem [logic [31:0]];
    int n_checks = 0, n_errors = 0, rd_count = 0;
    logic [1:0]  r_status;
    logic [19:0] r_rpn;
    logic        r_pr, r_pw;
    vec_t        v;
    logic [31:0] a, a2;

    function automatic logic [31:0] rd_mem(input logic [31:0] ad);
        return mem.exists(ad) ? mem[ad] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) mem_rdata <= 32'h0;
        else begin
            if (mem_rd_en) mem_rdata <= rd_mem(mem_addr);
            if (mem_wr_en) mem[mem_addr] = mem_wdata;
        end
    end

    always @(negedge clk) if (mem_rd_en) rd_count++;

    function automatic logic [31:0] grp_of(input logic [23:0] vs, input logic [15:0] p,
                                           input logic [15:0] org, input logic [8:0] sz, input bit sec);
        logic [31:0] h;
        h = {7'b0, vs[18:0] ^ {3'b0, p}, 6'b0};
        if (sec) h = ~h & 32'h01FFFFC0;
        return {org, 16'h0} | (h & {7'b0, sz, 16'hFFC0});
    endfunction

    function automatic logic [31:0] w0_of(input logic [23:0] vs, input logic [15:0] p, input bit h);
        return {1'b1, vs, h, p[15:10]};
    endfunction

    function automatic logic [31:0] w1_of(input logic [1:0] rc, input logic [1:0] pp);
        return {20'h12345, 3'b0, rc[1], rc[0], 5'b0, pp};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input logic [23:0] vs, input logic [15:0] p, input logic wr, input logic usr,
                            input logic ks, input logic kp, input logic [15:0] org, input logic [8:0] sz);
        int waitc;
        @(negedge clk);
        req_vsid = vs; req_pidx = p; req_write = wr; req_user = usr;
        seg_key_sup = ks; seg_key_usr = kp; tbl_origin = org; tbl_size = sz;
        req_valid = 1'b1; rd_count = 0;
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (!done && waitc < 400) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) check(1'b0, "R10 done never seen", 32'h0, 32'h1);
        r_status = status; r_rpn = real_page; r_pr = perm_read; r_pw = perm_write;
        @(negedge clk);
        check(!done, "R10 done lasts one cycle", {31'h0, done}, 32'h0);
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vsid = '0; req_pidx = '0; req_write = 1'b0;
        req_user = 1'b0; seg_key_sup = 1'b0; seg_key_usr = 1'b0; tbl_origin = ORG; tbl_size = SZ;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle after reset
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R12 reset idle",
              {28'h0, busy, done, mem_rd_en, mem_wr_en}, 32'h0);

        // Vector table: R1 R2 R3 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            mem.delete();
            a = grp_of(v.vsid, v.pidx, ORG, SZ, v.where == 2'd2) + {26'h0, v.slot, 3'b000};
            if (v.where != 2'd0) begin
                mem[a]     = w0_of(v.vsid, v.pidx, v.where == 2'd2);
                mem[a + 4] = w1_of(v.rc, v.pp);
            end
            run_walk(v.vsid, v.pidx, v.wr, v.usr, v.ks, v.kp, ORG, SZ);
            check(r_status == v.est, $sformatf("R10 status vec%0d", i), {30'h0, r_status}, {30'h0, v.est});
            check(r_pr == v.er, $sformatf("R5 R6 perm_read vec%0d", i), {31'h0, r_pr}, {31'h0, v.er});
            check(r_pw == v.ew, $sformatf("R8 perm_write vec%0d", i), {31'h0, r_pw}, {31'h0, v.ew});
            if (v.est == S_HIT)
                check(r_rpn == 20'h12345, $sformatf("R9 real_page vec%0d", i), {12'h0, r_rpn}, 32'h00012345);
            if (v.where != 2'd0)
                check(rd_mem(a + 4) == v.eword, $sformatf("R7 stored word vec%0d", i), rd_mem(a + 4), v.eword);
            check(rd_count == ((v.where == 2'd1) ? 16 : 32), $sformatf("R11 R2 read count vec%0d", i),
                  rd_count, (v.where == 2'd1) ? 32'd16 : 32'd32);
        end

        // R4: inconsistent duplicates
        mem.delete();
        a = grp_of(24'h0C0C0C, 16'h4321, ORG, SZ, 1'b0);
        mem[a + 8]  = w0_of(24'h0C0C0C, 16'h4321, 1'b0); mem[a + 12] = 32'h12345002;
        mem[a + 40] = w0_of(24'h0C0C0C, 16'h4321, 1'b0); mem[a + 44] = 32'h12345001;
        run_walk(24'h0C0C0C, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_CONF, "R4 conflict status", {30'h0, r_status}, {30'h0, S_CONF});
        check(rd_mem(a + 12) == 32'h12345002, "R4 conflict no write", rd_mem(a + 12), 32'h12345002);
        check(!r_pr && !r_pw, "R10 no perms on conflict", {30'h0, r_pr, r_pw}, 32'h0);

        // R4 R7: agreeing duplicates differing only in bit 7 use the first slot
        mem.delete();
        a = grp_of(24'h111111, 16'h2222, ORG, SZ, 1'b0);
        mem[a + 16] = w0_of(24'h111111, 16'h2222, 1'b0); mem[a + 20] = 32'h12345002;
        mem[a + 48] = w0_of(24'h111111, 16'h2222, 1'b0); mem[a + 52] = 32'h12345082;
        run_walk(24'h111111, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_HIT, "R4 agreeing duplicates hit", {30'h0, r_status}, 32'h0);
        check(rd_mem(a + 20) == 32'h12345102, "R7 first slot updated", rd_mem(a + 20), 32'h12345102);
        check(rd_mem(a + 52) == 32'h12345082, "R7 later slot untouched", rd_mem(a + 52), 32'h12345082);
        check(!r_pw, "R8 read withholds write", {31'h0, r_pw}, 32'h0);

        // R3: wrong pass bit in first group
        mem.delete();
        a = grp_of(24'h333333, 16'h4444, ORG, SZ, 1'b0);
        mem[a] = w0_of(24'h333333, 16'h4444, 1'b1); mem[a + 4] = 32'h12345002;
        run_walk(24'h333333, 16'h4444, 1'b0, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_NONE, "R3 pass bit mismatch ignored", {30'h0, r_status}, {30'h0, S_NONE});

        // R3: valid bit clear
        mem.delete();
        a = grp_of(24'h444444, 16'h5555, ORG, SZ, 1'b0);
        mem[a] = w0_of(24'h444444, 16'h5555, 1'b0) & 32'h7FFFFFFF; mem[a + 4] = 32'h12345002;
        run_walk(24'h444444, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_NONE, "R3 invalid entry ignored", {30'h0, r_status}, {30'h0, S_NONE});
        check(rd_mem(a + 4) == 32'h12345002, "R3 invalid entry untouched", rd_mem(a + 4), 32'h12345002);

        // R3: abbreviated page index differs
        mem.delete();
        a = grp_of(24'h555555, 16'h6666, ORG, SZ, 1'b0);
        mem[a] = w0_of(24'h555555, 16'h6666 ^ 16'h0400, 1'b0); mem[a + 4] = 32'h12345002;
        run_walk(24'h555555, 16'h6666, 1'b0, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_NONE, "R3 tag mismatch ignored", {30'h0, r_status}, {30'h0, S_NONE});

        // R2: a refused match in the first group stops the walk
        mem.delete();
        a  = grp_of(24'h666666, 16'h7777, ORG, SZ, 1'b0) + 24;
        a2 = grp_of(24'h666666, 16'h7777, ORG, SZ, 1'b1);
        mem[a]  = w0_of(24'h666666, 16'h7777, 1'b0); mem[a + 4]  = 32'h12345003;
        mem[a2] = w0_of(24'h666666, 16'h7777, 1'b1); mem[a2 + 4] = 32'h12345002;
        run_walk(24'h666666, 16'h7777, 1'b1, 1'b0, 1'b0, 1'b0, ORG, SZ);
        check(r_status == S_PROT, "R2 first-group refusal final", {30'h0, r_status}, {30'h0, S_PROT});
        check(rd_mem(a2 + 4) == 32'h12345002, "R2 second group untouched", rd_mem(a2 + 4), 32'h12345002);
        check(rd_count == 16, "R2 second group not read", rd_count, 32'd16);

        // R1: size mask admits hash bits 17..16
        mem.delete();
        a = grp_of(24'h000000, 16'h0C00, 16'h0100, 9'h003, 1'b0);
        mem[a] = w0_of(24'h000000, 16'h0C00, 1'b0); mem[a + 4] = 32'h12345002;
        run_walk(24'h000000, 16'h0C00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0100, 9'h003);
        check(a == 32'h01030000, "R1 bench group address", a, 32'h01030000);
        check(r_status == S_HIT, "R1 sized table hit", {30'h0, r_status}, 32'h0);
        check(rd_mem(a + 4) == 32'h12345102, "R1 R7 sized table update", rd_mem(a + 4), 32'h12345102);

        report();
    end
endmodule